// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address by walking a two-level page table held in memory. A requester gives it a linear address, a read/write access type and the current privilege level. The walker then fetches a directory entry and a page-table entry through a single memory read port, one read at a time. It returns either the physical address or a page fault. When a fault is reported, the faulting linear address is kept in a fault-address register.

The walker also holds a paging-enable bit and the directory base. Both are loaded through a small configuration write port. While paging is off, each address passes through unchanged and no memory read takes place. Every entry is a 32-bit word with this layout:

- bit 0: present
- bit 1: writable
- bit 2: user-accessible
- bits [31:12]: base of the next level

The permission flags are checked at both levels, and both levels must allow the access.

Top module: `pt_walker`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid is 0, mem_valid is 0, fault_addr is 0 and paging is disabled.
- R2: When paging is disabled, an accepted request returns rsp_paddr equal to req_laddr with rsp_fault 0. rsp_valid rises in the cycle after acceptance, and no memory read is issued.
- R3: With paging enabled, the first read goes to {cfg_root, 12'h000} + 4*laddr[31:22]. The second read goes to {dir_entry[31:12], 12'h000} + 4*laddr[21:12].
- R4: When both entries allow the access, the walk ends with rsp_fault 0 and rsp_paddr = {table_entry[31:12], laddr[11:0]}, after exactly two memory reads.
- R5: An entry with bit 0 (present) clear faults. A non-present directory entry ends the walk after one read.
- R6: A write access faults if bit 1 (writable) is 0 in either entry. A read access ignores bit 1.
- R7: At privilege level 3, an access faults if bit 2 (user) is 0 in either entry. Privilege levels 0 to 2 ignore bit 2.
- R8: A fault gives rsp_valid with rsp_fault 1 and loads fault_addr with the request's linear address. fault_addr changes at no other time.
- R9: mem_valid stays high with mem_addr stable until mem_ready, and only one read is outstanding. A read completes in the cycle where mem_valid and mem_ready are both 1, with data on mem_rdata.
- R10: cfg_wr loads the paging-enable bit and the directory base. req_ready is low from acceptance until the response. rsp_valid is a one-cycle pulse, after which req_ready returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_wr | input | 1 | Load configuration |
| cfg_pg_en | input | 1 | Paging-enable value to load |
| cfg_root | input | 20 | Directory base (physical, 4 KiB aligned) to load |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and accepting |
| req_laddr | input | 32 | Linear address |
| req_write | input | 1 | 1 = write access, 0 = read |
| req_cpl | input | 2 | Current privilege level |
| mem_valid | output | 1 | Memory read request |
| mem_ready | input | 1 | Read completes, data valid |
| mem_addr | output | 32 | Entry address |
| mem_rdata | input | 32 | Entry read |
| rsp_valid | output | 1 | Result pulse |
| rsp_fault | output | 1 | Result is a page fault |
| rsp_paddr | output | 32 | Physical address |
| fault_addr | output | 32 | Last faulting linear address |

## Verification
A walker stuck in a wrong state shows at the ports right away. Three symptoms reveal it:

- a memory read where bypass allows none;
- a third read, or a second read after a directory-level fault;
- a response that arrives in the wrong cycle.

Each of these is visible within one to three cycles of the read that went wrong. A latched request field or base register that is corrupted shows up as a wrong entry address on mem_addr, or as a wrong physical address or fault flag in the same walk. A fault-address register written at the wrong time shows up when it is read back after a later successful walk.

// File: rtl/pt_walker.sv
module pt_walker (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr,
  input  logic        cfg_pg_en,
  input  logic [19:0] cfg_root,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_laddr,
  input  logic        req_write,
  input  logic [1:0]  req_cpl,
  output logic        mem_valid,
  input  logic        mem_ready,
  output logic [31:0] mem_addr,
  input  logic [31:0] mem_rdata,
  output logic        rsp_valid,
  output logic        rsp_fault,
  output logic [31:0] rsp_paddr,
  output logic [31:0] fault_addr
);

  typedef enum logic [2:0] {S_IDLE, S_DIR, S_TBL, S_DONE, S_FAULT} st_t;

  st_t         st;
  logic        pg_en;
  logic [19:0] root;
  logic [31:0] la;
  logic        wr;
  logic [1:0]  cpl;
  logic [19:0] tbase;
  logic [31:0] paddr;

  logic ent_ok;
  assign ent_ok = mem_rdata[0] && (!wr || mem_rdata[1]) && (mem_rdata[2] || cpl != 2'd3);

  assign req_ready = (st == S_IDLE);
  assign mem_valid = (st == S_DIR) || (st == S_TBL);
  assign mem_addr  = (st == S_TBL) ? ({tbase, 12'h000} + {20'h0, la[21:12], 2'b00})
                                   : ({root, 12'h000} + {20'h0, la[31:22], 2'b00});
  assign rsp_valid = (st == S_DONE) || (st == S_FAULT);
  assign rsp_fault = (st == S_FAULT);
  assign rsp_paddr = paddr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pg_en <= 1'b0;
      root  <= '0;
    end else if (cfg_wr) begin
      pg_en <= cfg_pg_en;
      root  <= cfg_root;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      la         <= '0;
      wr         <= 1'b0;
      cpl        <= '0;
      tbase      <= '0;
      paddr      <= '0;
      fault_addr <= '0;
    end else begin
      case (st)
        S_IDLE:
          if (req_valid) begin
            la  <= req_laddr;
            wr  <= req_write;
            cpl <= req_cpl;
            if (pg_en) st <= S_DIR;
            else begin
              paddr <= req_laddr;
              st    <= S_DONE;
            end
          end
        S_DIR:
          if (mem_ready) begin
            if (ent_ok) begin
              tbase <= mem_rdata[31:12];
              st    <= S_TBL;
            end else begin
              fault_addr <= la;
              st         <= S_FAULT;
            end
          end
        S_TBL:
          if (mem_ready) begin
            if (ent_ok) begin
              paddr <= {mem_rdata[31:12], la[11:0]};
              st    <= S_DONE;
            end else begin
              fault_addr <= la;
              st         <= S_FAULT;
            end
          end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_mem_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr));

  assert_bypass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready && req_valid && !pg_en |=> rsp_valid && !rsp_fault && !mem_valid
      && rsp_paddr == $past(req_laddr));

  assert_fault_reg_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fault_addr) |-> rsp_valid && rsp_fault);

  assert_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> req_ready && !rsp_valid);

  assert_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> !req_ready && !rsp_valid);

endmodule

// File: tb/tb_pt_walker.sv
module tb_pt_walker;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        cfg_wr = 0, cfg_pg_en = 0;
  logic [19:0] cfg_root = '0;
  logic        req_valid = 0;
  logic        req_ready;
  logic [31:0] req_laddr = '0;
  logic        req_write = 0;
  logic [1:0]  req_cpl = '0;
  logic        mem_valid;
  logic        mem_ready = 0;
  logic [31:0] mem_addr;
  logic [31:0] mem_rdata = '0;
  logic        rsp_valid, rsp_fault;
  logic [31:0] rsp_paddr, fault_addr;

  int checks = 0, fails = 0;
  int reads = 0, lat = 0, wait_cnt = 0;
  logic [31:0] rd_addr [0:3];
  logic [31:0] mem [logic [31:0]];

  always #10 clk = ~clk;

  pt_walker dut (.*);

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  always @(negedge clk) begin
    if (mem_valid && !mem_ready) begin
      if (wait_cnt >= lat) begin
        mem_ready = 1;
        mem_rdata = rd(mem_addr);
        wait_cnt = 0;
      end else wait_cnt++;
    end else mem_ready = 0;
  end

  always @(posedge clk)
    if (mem_valid && mem_ready) begin
      if (reads < 4) rd_addr[reads] <= mem_addr;
      reads <= reads + 1;
    end

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic cfg(input logic en, input logic [19:0] rt);
    @(negedge clk);
    cfg_wr = 1; cfg_pg_en = en; cfg_root = rt;
    @(negedge clk);
    cfg_wr = 0;
  endtask

  task automatic walk(input string rq, input logic [31:0] la, input logic w, input logic [1:0] c,
                      input logic ef, input logic [31:0] ep, input int er);
    int n;
    @(negedge clk);
    reads = 0;
    req_valid = 1; req_laddr = la; req_write = w; req_cpl = c;
    @(negedge clk);
    req_valid = 0;
    n = 0;
    if (!rsp_valid) chk({rq, " busy R10"}, {31'b0, req_ready}, 32'd0);
    while (!rsp_valid && n < 50) begin
      @(negedge clk);
      n++;
    end
    chk({rq, " valid"}, {31'b0, rsp_valid}, 32'd1);
    chk({rq, " fault"}, {31'b0, rsp_fault}, {31'b0, ef});
    if (!ef) chk({rq, " paddr"}, rsp_paddr, ep);
    else chk({rq, " fault_addr R8"}, fault_addr, la);
    chk({rq, " reads"}, reads, er);
    @(negedge clk);
    chk({rq, " pulse R10"}, {30'b0, rsp_valid, req_ready}, 32'd1);
  endtask

  task automatic t_reset;
    chk("R1 req_ready", {31'b0, req_ready}, 32'd1);
    chk("R1 rsp_valid", {31'b0, rsp_valid}, 32'd0);
    chk("R1 mem_valid", {31'b0, mem_valid}, 32'd0);
    chk("R1 fault_addr", fault_addr, 32'd0);
  endtask

  task automatic t_bypass;
    walk("R2 bypass", 32'hDEAD_B123, 1'b1, 2'd3, 1'b0, 32'hDEAD_B123, 0);
    walk("R2 bypass2", 32'h0040_5123, 1'b0, 2'd0, 1'b0, 32'h0040_5123, 0);
  endtask

  task automatic t_basic;
    walk("R4 ok", 32'h0040_5123, 1'b1, 2'd3, 1'b0, 32'h0ABC_D123, 2);
    chk("R3 dir addr", rd_addr[0], 32'h0001_0004);
    chk("R3 tbl addr", rd_addr[1], 32'h0002_0014);
    walk("R4 ok2", 32'h00C0_0FFF, 1'b0, 2'd3, 1'b0, 32'h0E00_EFFF, 2);
    chk("R3 dir addr2", rd_addr[0], 32'h0001_000C);
    chk("R3 tbl addr2", rd_addr[1], 32'h0002_2000);
  endtask

  task automatic t_present;
    walk("R5 tbl np", 32'h0040_8010, 1'b0, 2'd0, 1'b1, 0, 2);
    walk("R5 dir np", 32'h0100_0020, 1'b0, 2'd0, 1'b1, 0, 1);
  endtask

  task automatic t_rw;
    walk("R6 tbl ro write", 32'h0040_6004, 1'b1, 2'd3, 1'b1, 0, 2);
    walk("R6 tbl ro read", 32'h0040_6004, 1'b0, 2'd3, 1'b0, 32'h0BEE_F004, 2);
    walk("R6 dir ro write", 32'h00C0_0008, 1'b1, 2'd0, 1'b1, 0, 1);
  endtask

  task automatic t_us;
    walk("R7 tbl sup cpl3", 32'h0040_7ABC, 1'b0, 2'd3, 1'b1, 0, 2);
    walk("R7 tbl sup cpl2", 32'h0040_7ABC, 1'b1, 2'd2, 1'b0, 32'h0CAF_EABC, 2);
    walk("R7 dir sup cpl3", 32'h0080_0100, 1'b0, 2'd3, 1'b1, 0, 1);
    walk("R7 dir sup cpl0", 32'h0080_0100, 1'b1, 2'd0, 1'b0, 32'h0D00_D100, 2);
  endtask

  task automatic t_hold;
    walk("R8 fault", 32'h0040_8777, 1'b0, 2'd0, 1'b1, 0, 2);
    walk("R8 ok after", 32'h0040_5000, 1'b0, 2'd0, 1'b0, 32'h0ABC_D000, 2);
    chk("R8 fault_addr held", fault_addr, 32'h0040_8777);
  endtask

  task automatic t_latency;
    lat = 3;
    walk("R9 slow mem", 32'h0040_5456, 1'b0, 2'd1, 1'b0, 32'h0ABC_D456, 2);
    chk("R9 slow tbl addr", rd_addr[1], 32'h0002_0014);
    lat = 0;
  endtask

  initial begin
    mem[32'h0001_0004] = 32'h0002_0007;
    mem[32'h0002_0014] = 32'h0ABC_D007;
    mem[32'h0002_0018] = 32'h0BEE_F005;
    mem[32'h0002_001C] = 32'h0CAF_E003;
    mem[32'h0001_0008] = 32'h0002_1003;
    mem[32'h0002_1000] = 32'h0D00_D007;
    mem[32'h0001_000C] = 32'h0002_2005;
    mem[32'h0002_2000] = 32'h0E00_E007;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_bypass();
    cfg(1'b1, 20'h00010);
    t_basic();
    t_present();
    t_rw();
    t_us();
    t_hold();
    t_latency();
    cfg(1'b0, 20'h00010);
    walk("R10 cfg off", 32'h0040_5123, 1'b0, 2'd0, 1'b0, 32'h0040_5123, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule